// File: doc/BRIEF.md
# Wired Interrupt Source State Bank

This block holds the per-source state for a bank of wired interrupt inputs. Every source has a configuration word, a pending bit, an enable bit and a register with the input level seen on the last clock. A 3-bit mode picks rising-edge, falling-edge, level-high or level-low detection. A source can also be made detached, inactive, or delegated to a child domain. For each source the block gives the "pending and enabled" vector, and a single-cycle strobe marks any change of pending or enable state. A priority arbiter or a message generator downstream uses these outputs.

Software reaches the state through a plain 32-bit write port and a combinational read port. Pending and enable bits can be set or cleared in two ways: a whole word at a time, or one source at a time by writing its number. Reads return the configuration, the pending bitmap, the enable bitmap and the rectified-input bitmap. A parameter fixes the delivery style: direct wire delivery or message-signalled. The delivery style changes how software may touch pending bits on level-mode sources.

Top module: `irq_source_bank`

## Requirements
- R1: After reset every configuration word, pending bit and enable bit is zero, `pendEn` and `stateChg` are low, and all reads return zero. Region 4 reads always return zero.
- R2: Address bits [11:8] select a region and bits [7:0] give an index. In region 0 the index is the source number, and a write stores the configuration word. If data bit 10 is set, the word is stored as bit 10 plus a 10-bit child index in bits [9:0], and it drives `delegated` and `childIdx`. If data bit 10 is clear, only the mode in bits [2:0] is kept. If the block has no child domains, a write with bit 10 set stores zero. Source 0 always reads zero and cannot be written.
- R3: A region 2 read returns word `idx` of the rectified inputs. For each source this is the stored input level XOR an invert flag, and the flag is set for modes 5 and 7. It reads 0 for source 0, out-of-range sources, mode 0 sources and delegated sources.
- R4: In mode 4 (rising), a 0-to-1 input change sets pending. In mode 5 (falling), a 1-to-0 change sets pending. An input that stays steady does not set pending again after a clear.
- R5: In mode 6 (level high) or mode 7 (level low), pending is set on any clock where the input is at its active level.
- R6: Software set or clear of pending on a mode 6 or 7 source has no effect under direct delivery. Under message delivery, clear has no effect, and set takes effect only while the stored input is at the active level.
- R7: Set and clear of pending and enable have no effect on source 0, on sources beyond the bank, on mode 0 sources and on delegated sources.
- R8: A configuration write of zero, or of a delegated word, clears both pending and enable. A write of any other mode sets pending at once if the new rectified input is 1.
- R9: In region 1 (set pending), region 2 (clear pending), region 3 (set enable) and region 4 (clear enable), data bit i of word `idx` addresses source 32*idx+i. A region 1 read returns the pending word and a region 3 read returns the enable word. Changes appear on the clock edge after the write.
- R10: Region 5 takes a source number as the write data. Index 0 sets pending, 1 clears pending, 2 sets enable and 3 clears enable. Index 4 sets pending after a byte swap of the data.
- R11: `pendEn` is pending AND enable for each source. `stateChg` is high for exactly one cycle after any clock edge that changed a pending or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NUM_SRC | Raw wired interrupt inputs, synchronous to clk |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Write address: region [11:8], index [7:0] |
| wrData | input | 32 | Write data |
| rdAddr | input | 12 | Read address: region [11:8], index [7:0] |
| rdData | output | 32 | Combinational read data |
| pendEn | output | NUM_SRC | Per-source pending and enabled |
| delegated | output | NUM_SRC | Per-source delegate flag |
| childIdx | output | NUM_SRC*10 | Per-source child index, 10 bits per source |
| stateChg | output | 1 | One-cycle strobe after a pending or enable change |

## Verification
The bench targets the level-mode rules. A design that lets software clear a level source under direct delivery would lose a live request. A design that accepts a software set on an inactive level under message delivery would raise a false interrupt. The bench also checks that an edge source held high does not pend again once cleared, since a design that treated the edge as a level would storm the downstream arbiter. Other checks cover the immediate pend on a configuration write whose rectified input is already 1, the byte-swapped set-by-number path, writes to source 0 and to delegated sources, and a delegate write in a domain without children. A design that got any of these wrong would show a wrong pending, enable or configuration word on read-back.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int CFG_W     = 11;
  localparam int DELEG_BIT = 10;
  localparam int CHILD_W   = 10;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_DETACH = 3'd1,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_HIGH   = 3'd6,
    MODE_LOW    = 3'd7
  } srcMode_e;

  typedef enum logic [3:0] {
    RG_CFG    = 4'd0,
    RG_SETP   = 4'd1,
    RG_CLRP   = 4'd2,
    RG_SETE   = 4'd3,
    RG_CLRE   = 4'd4,
    RG_BYNUM  = 4'd5
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        cfgWr;
    logic        setPend;
    logic        clrPend;
    logic        setEn;
    logic        clrEn;
    logic        byNum;
    logic [7:0]  idx;
    logic [31:0] data;
  } wrCmd_t;

endpackage

// File: rtl/isb_ctrl.sv
module isb_ctrl
  import irq_src_pkg::*;
(
  input  logic        wrEn,
  input  logic [11:0] wrAddr,
  input  logic [31:0] wrData,
  output wrCmd_t      cmd
);

  always_comb begin
    cmd      = '0;
    cmd.idx  = wrAddr[7:0];
    cmd.data = wrData;
    if (wrEn) begin
      case (region_e'(wrAddr[11:8]))
        RG_CFG:  cmd.cfgWr   = 1'b1;
        RG_SETP: cmd.setPend = 1'b1;
        RG_CLRP: cmd.clrPend = 1'b1;
        RG_SETE: cmd.setEn   = 1'b1;
        RG_CLRE: cmd.clrEn   = 1'b1;
        RG_BYNUM: begin
          cmd.byNum = 1'b1;
          case (wrAddr[7:0])
            8'd0: cmd.setPend = 1'b1;
            8'd1: cmd.clrPend = 1'b1;
            8'd2: cmd.setEn   = 1'b1;
            8'd3: cmd.clrEn   = 1'b1;
            8'd4: begin
              cmd.setPend = 1'b1;
              cmd.data    = {wrData[7:0], wrData[15:8], wrData[23:16], wrData[31:24]};
            end
            default: cmd.byNum = 1'b0;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/isb_cell.sv
module isb_cell
  import irq_src_pkg::*;
#(
  parameter bit HAS_CHILD = 1'b1,
  parameter bit MSG_MODE  = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] wrCfg,
  input  logic             swSetPend,
  input  logic             swClrPend,
  input  logic             swSetEn,
  input  logic             swClrEn,
  output logic [CFG_W-1:0] cfg,
  output logic             pend,
  output logic             en,
  output logic             rect,
  output logic             changed
);

  logic             lastIn;
  logic             active, inv, isLevel, hwSet, setOk, clrOk;
  logic [CFG_W-1:0] newCfg;
  logic             newActive, newRect;
  logic             pendNxt, enNxt;

  function automatic logic invOf(input logic [2:0] m);
    return (m == MODE_FALL) || (m == MODE_LOW);
  endfunction

  assign active  = !cfg[DELEG_BIT] && (cfg[2:0] != MODE_OFF);
  assign inv     = invOf(cfg[2:0]);
  assign isLevel = (cfg[2:0] == MODE_HIGH) || (cfg[2:0] == MODE_LOW);
  assign rect    = active && (lastIn ^ inv);

  always_comb begin
    hwSet = 1'b0;
    if (active && !pend) begin
      case (srcMode_e'(cfg[2:0]))
        MODE_RISE: hwSet = rawIn && !lastIn;
        MODE_FALL: hwSet = !rawIn && lastIn;
        MODE_HIGH: hwSet = rawIn;
        MODE_LOW:  hwSet = !rawIn;
        default:   hwSet = 1'b0;
      endcase
    end
  end

  assign setOk = active && (!isLevel || (MSG_MODE && (lastIn ^ inv)));
  assign clrOk = active && !isLevel;

  always_comb begin
    if (wrCfg[DELEG_BIT])
      newCfg = HAS_CHILD ? {1'b1, wrCfg[CHILD_W-1:0]} : '0;
    else
      newCfg = {{(CFG_W-3){1'b0}}, wrCfg[2:0]};
  end
  assign newActive = !newCfg[DELEG_BIT] && (newCfg[2:0] != MODE_OFF);
  assign newRect   = newActive && (lastIn ^ invOf(newCfg[2:0]));

  always_comb begin
    pendNxt = pend;
    enNxt   = en;
    if (cfgWr) begin
      if (!newActive) begin
        pendNxt = 1'b0;
        enNxt   = 1'b0;
      end else begin
        pendNxt = pend || newRect || hwSet;
      end
    end else begin
      if (swClrPend && clrOk) pendNxt = 1'b0;
      if ((swSetPend && setOk) || hwSet) pendNxt = 1'b1;
      if (active && swClrEn) enNxt = 1'b0;
      if (active && swSetEn) enNxt = 1'b1;
    end
  end

  assign changed = (pendNxt != pend) || (enNxt != en);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      pend   <= 1'b0;
      en     <= 1'b0;
      lastIn <= 1'b0;
    end else begin
      if (cfgWr) cfg <= newCfg;
      pend   <= pendNxt;
      en     <= enNxt;
      lastIn <= rawIn;
    end
  end

endmodule

// File: rtl/isb_datapath.sv
module isb_datapath
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter bit HAS_CHILD = 1'b1,
  parameter bit MSG_MODE  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcIn,
  input  wrCmd_t                     cmd,
  input  logic [11:0]                rdAddr,
  output logic [31:0]                rdData,
  output logic [NUM_SRC-1:0]         pendEn,
  output logic [NUM_SRC-1:0]         delegated,
  output logic [NUM_SRC*CHILD_W-1:0] childIdx,
  output logic                       stateChg
);

  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  logic [NUM_SRC-1:0] pendV, enV, rectV, chgV;
  logic [CFG_W-1:0]   cfgA [NUM_SRC];
  logic [PAD_W-1:0]   padPend, padEn, padRect;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_zero
      assign cfgA[s]  = '0;
      assign pendV[s] = 1'b0;
      assign enV[s]   = 1'b0;
      assign rectV[s] = 1'b0;
      assign chgV[s]  = 1'b0;
    end else begin : g_cell
      logic hit;
      assign hit = cmd.byNum ? (cmd.data == 32'(s))
                             : ((cmd.idx == 8'(s / 32)) && cmd.data[s % 32]);
      isb_cell #(.HAS_CHILD(HAS_CHILD), .MSG_MODE(MSG_MODE)) cell_i (
        .clk       (clk),
        .rstN      (rstN),
        .rawIn     (srcIn[s]),
        .cfgWr     (cmd.cfgWr && (cmd.idx == 8'(s))),
        .wrCfg     (cmd.data[CFG_W-1:0]),
        .swSetPend (cmd.setPend && hit),
        .swClrPend (cmd.clrPend && hit),
        .swSetEn   (cmd.setEn && hit),
        .swClrEn   (cmd.clrEn && hit),
        .cfg       (cfgA[s]),
        .pend      (pendV[s]),
        .en        (enV[s]),
        .rect      (rectV[s]),
        .changed   (chgV[s])
      );
    end
    assign delegated[s]                 = cfgA[s][DELEG_BIT];
    assign childIdx[s*CHILD_W +: CHILD_W] = cfgA[s][DELEG_BIT] ? cfgA[s][CHILD_W-1:0] : '0;
  end

  assign pendEn  = pendV & enV;
  assign padPend = PAD_W'(pendV);
  assign padEn   = PAD_W'(enV);
  assign padRect = PAD_W'(rectV);

  always_comb begin
    rdData = '0;
    case (region_e'(rdAddr[11:8]))
      RG_CFG: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (rdAddr[7:0] == 8'(s)) rdData = 32'(cfgA[s]);
      end
      RG_SETP, RG_CLRP, RG_SETE: begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (rdAddr[7:0] == 8'(w)) begin
            if (rdAddr[11:8] == RG_SETP)      rdData = padPend[w*32 +: 32];
            else if (rdAddr[11:8] == RG_CLRP) rdData = padRect[w*32 +: 32];
            else                              rdData = padEn[w*32 +: 32];
          end
        end
      end
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateChg <= 1'b0;
    else       stateChg <= |chgV;
  end

endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 40,
  parameter bit HAS_CHILD = 1'b1,
  parameter bit MSG_MODE  = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcIn,
  input  logic                  wrEn,
  input  logic [11:0]           wrAddr,
  input  logic [31:0]           wrData,
  input  logic [11:0]           rdAddr,
  output logic [31:0]           rdData,
  output logic [NUM_SRC-1:0]    pendEn,
  output logic [NUM_SRC-1:0]    delegated,
  output logic [NUM_SRC*10-1:0] childIdx,
  output logic                  stateChg
);

  wrCmd_t cmd;

  isb_ctrl ctrl_i (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cmd    (cmd)
  );

  isb_datapath #(.NUM_SRC(NUM_SRC), .HAS_CHILD(HAS_CHILD), .MSG_MODE(MSG_MODE)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .cmd       (cmd),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .pendEn    (pendEn),
    .delegated (delegated),
    .childIdx  (childIdx),
    .stateChg  (stateChg)
  );

endmodule

// File: rtl/irq_source_bank_chk.sv
module irq_source_bank_chk #(
  parameter int NUM_SRC   = 40,
  parameter bit HAS_CHILD = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [11:0]        rdAddr,
  input logic [31:0]        rdData,
  input logic [NUM_SRC-1:0] pendEn,
  input logic [NUM_SRC-1:0] delegated,
  input logic               stateChg
);

  p_change_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pendEn != $past(pendEn)) |-> stateChg);

  p_no_deleg_pend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendEn & delegated) == '0);

  p_src0_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !pendEn[0] && !delegated[0]);

  p_child_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    HAS_CHILD || (delegated == '0));

  p_idle_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[11:8] == 4'h4) |-> (rdData == '0));

endmodule

bind irq_source_bank irq_source_bank_chk #(.NUM_SRC(NUM_SRC), .HAS_CHILD(HAS_CHILD)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .pendEn    (pendEn),
  .delegated (delegated),
  .stateChg  (stateChg)
);

// File: tb/irq_source_bank_tb_top.sv
module irq_source_bank_tb_top;

  localparam int NSRC = 40;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NSRC-1:0]   srcIn = '0, srcInM = '0;
  logic              wrEn = 1'b0, wrEnM = 1'b0;
  logic [11:0]       wrAddr = '0, rdAddr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData, rdDataM;
  logic [NSRC-1:0]   pendEn, pendEnM, delegated, delegatedM;
  logic [NSRC*10-1:0] childIdx, childIdxM;
  logic              stateChg, stateChgM;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  irq_source_bank #(.NUM_SRC(NSRC), .HAS_CHILD(1'b1), .MSG_MODE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .pendEn(pendEn),
    .delegated(delegated), .childIdx(childIdx), .stateChg(stateChg));

  irq_source_bank #(.NUM_SRC(NSRC), .HAS_CHILD(1'b0), .MSG_MODE(1'b1)) dutMsg_i (
    .clk(clk), .rstN(rstN), .srcIn(srcInM), .wrEn(wrEnM), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdDataM), .pendEn(pendEnM),
    .delegated(delegatedM), .childIdx(childIdxM), .stateChg(stateChgM));

  // {wrAddr, wrData, rdAddr, expected}
  localparam int NVEC = 22;
  localparam logic [87:0] TBL [NVEC] = '{
    {12'h003, 32'h4,        12'h003, 32'h4},
    {12'h005, 32'h5,        12'h100, 32'h20},
    {12'h007, 32'h7,        12'h100, 32'hA0},
    {12'hF00, 32'h0,        12'h200, 32'hA0},
    {12'h100, 32'h8,        12'h100, 32'hA8},
    {12'h200, 32'hA8,       12'h100, 32'h80},
    {12'h300, 32'hFF,       12'h300, 32'hA8},
    {12'h021, 32'h6,        12'h021, 32'h6},
    {12'h101, 32'h2,        12'h101, 32'h0},
    {12'h022, 32'h4,        12'h022, 32'h4},
    {12'h101, 32'h4,        12'h101, 32'h4},
    {12'h502, 32'd34,       12'h301, 32'h4},
    {12'h504, 32'h03000000, 12'h100, 32'h88},
    {12'h501, 32'h3,        12'h100, 32'h80},
    {12'h500, 32'h2,        12'h100, 32'h80},
    {12'h000, 32'h4,        12'h000, 32'h0},
    {12'h009, 32'h415,      12'h009, 32'h415},
    {12'h502, 32'h9,        12'h300, 32'hA8},
    {12'h004, 32'h1FB,      12'h004, 32'h3},
    {12'h005, 32'h0,        12'h300, 32'h88},
    {12'h400, 32'h8,        12'h300, 32'h80},
    {12'hF00, 32'h0,        12'h02D, 32'h0}
  };
  string tags [NVEC] = '{"R2","R8","R8","R3","R9","R6","R7","R2","R6","R2","R9",
                         "R10","R10","R10","R7","R7","R2","R7","R2","R8","R9","R7"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit toMsg, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrAddr = a;
    wrData = d;
    if (toMsg) wrEnM = 1'b1; else wrEn = 1'b1;
    @(negedge clk);
    wrEn  = 1'b0;
    wrEnM = 1'b0;
  endtask

  task automatic rd(input bit fromMsg, input logic [11:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = fromMsg ? rdDataM : rdData;
  endtask

  task automatic waitCyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 12'h100, v); check("R1 pending", v, 0);
    rd(0, 12'h003, v); check("R1 cfg", v, 0);
    check("R1 pendEn", 64'(pendEn), 0);
    check("R1 stateChg", 64'(stateChg), 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(0, TBL[i][87:76], TBL[i][75:44]);
      rd(0, TBL[i][43:32], v);
      check(tags[i], v, 64'(TBL[i][31:0]));
    end

    // R2 delegate outputs
    check("R2 delegated", 64'(delegated[9]), 1);
    check("R2 childIdx", 64'(childIdx[90 +: 10]), 64'h15);

    // R11 pendEn and strobe
    check("R11 pendEn", 64'(pendEn), (64'd1 << 7) | (64'd1 << 34));
    wr(0, 12'h401, 32'h4);
    check("R11 strobe high", 64'(stateChg), 1);
    check("R11 pendEn after clear", 64'(pendEn), 64'd1 << 7);
    waitCyc();
    check("R11 strobe low", 64'(stateChg), 0);

    // R4 rising edge on source 3
    srcIn[3] = 1'b1;
    waitCyc();
    rd(0, 12'h100, v); check("R4 rise pends", v, 32'h88);
    wr(0, 12'h200, 32'h8);
    waitCyc();
    rd(0, 12'h100, v); check("R4 held high no repend", v, 32'h80);
    // R3 rectified view: src3 rise in=1, src7 low in=0, src4 mode3 in=0, src9 delegated
    rd(0, 12'h200, v); check("R3 rectified", v, 32'h88);

    // R4 falling edge on source 6
    srcIn[6] = 1'b1;
    waitCyc();
    wr(0, 12'h006, 32'h5);
    rd(0, 12'h100, v); check("R4 fall cfg no pend", v, 32'h80);
    srcIn[6] = 1'b0;
    waitCyc();
    rd(0, 12'h100, v); check("R4 fall pends", v, 32'hC0);

    // R5 level high on source 33, R6 direct clear ignored
    srcIn[33] = 1'b1;
    waitCyc();
    rd(0, 12'h101, v); check("R5 level high", v, 32'h6);
    wr(0, 12'h501, 32'd33);
    rd(0, 12'h101, v); check("R6 direct clear ignored", v, 32'h6);

    // message-delivery instance
    wr(1, 12'h002, 32'h6);
    rd(1, 12'h100, v); check("R6 msg cfg", v, 0);
    wr(1, 12'h500, 32'h2);
    rd(1, 12'h100, v); check("R6 msg set inactive level", v, 0);
    srcInM[2] = 1'b1;
    waitCyc();
    rd(1, 12'h100, v); check("R5 msg level pends", v, 32'h4);
    wr(1, 12'h501, 32'h2);
    rd(1, 12'h100, v); check("R6 msg clear ignored", v, 32'h4);
    wr(1, 12'h005, 32'h4);
    wr(1, 12'h500, 32'h5);
    rd(1, 12'h100, v); check("R10 msg edge set", v, 32'h24);
    wr(1, 12'h003, 32'h405);
    rd(1, 12'h003, v); check("R2 no child stores zero", v, 0);
    check("R2 no child delegated", 64'(delegatedM), 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule